// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block turns one erase request, a start byte address and a byte length, into the chain of serial commands that a page-organised flash needs to erase that range. Before it issues anything, it checks the request against the page size and the device size. It then walks the range one step at a time. At each step it picks either a single-page erase or an eight-page block erase, and sends a four-byte command frame. After each frame it polls the device status until the device reports ready, and only then moves on to the next step.

The block talks to a byte-stream serial port that exchanges one byte per handshake. The block drives the chip select around every frame. The port itself does the bit shifting. A requester presents a request for one cycle. Completion is reported by a one-cycle `done` pulse, and a rejected request by a one-cycle `err` pulse. While a run is in progress, two counters show the current page index and the number of pages still to erase.

Top module: `flash_erase_seq`

## Requirements
- R1: A request whose start address is not a whole multiple of PAGE_BYTES is rejected: `err` is high for exactly one cycle, the cycle after the request is sampled. No frame is sent.
- R2: A request whose length is not a whole multiple of PAGE_BYTES is rejected in the same way as R1.
- R3: A request whose start plus length exceeds PAGE_BYTES*NUM_PAGES is rejected. A request that ends exactly at the last byte of the device is accepted.
- R4: The opcode of a step is 0x50 (block erase) when the current page index has its three low bits zero and at least eight pages remain. Otherwise it is 0x81 (page erase).
- R5: Each erase frame is four bytes, in order: the opcode, bits 23:16 of A, bits 15:8 of A, and 0x00. A is the page index shifted left by PAGE_SHIFT.
- R6: After an erase frame, the block sends status transactions made of the byte 0xD7 followed by a filler byte 0x00. The status is taken from the byte received during the filler. Polling repeats until bit 7 of that byte is 1, and no further erase frame is sent before that happens.
- R7: Before every status transaction, chip select stays high for exactly `poll_gap`+1 cycles.
- R8: A block step advances the page index by eight and lowers the remaining count by eight. A page step changes each by one. The number of frames therefore follows from the start page and the page count.
- R9: `done` is high for a single cycle after the last step reports ready. A valid zero-length request gives `done` in the cycle after it is sampled and sends no frame.
- R10: Chip select is low for the whole of each frame or status transaction and high between them. `xfer_req` is never high while chip select is high, and chip select is high while idle and after reset.
- R11: A request presented while the block is busy is ignored. The running erase sequence is not changed by it.
- R12: In the cycle after an accepted request, `cur_page` equals start/PAGE_BYTES and `pages_left` equals length/PAGE_BYTES. `pages_left` is 0 when `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Erase request strobe, sampled when idle |
| req_start | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W | Length in bytes |
| poll_gap | input | GAP_W | Extra idle cycles before each status poll |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| pages_left | output | PAGE_W | Pages still to erase |
| cur_page | output | PAGE_W | Page index of the current step |
| cs_n | output | 1 | Flash chip select, active low |
| xfer_req | output | 1 | Byte transfer requested, `xfer_tx` valid |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Byte exchange completes this cycle |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ack` |

## Verification
The bench aims at ranges that start off a block boundary and then cross one, ranges that end exactly at the device end, and ranges that overrun it by one page. A design that ignored alignment or the remaining count when choosing the opcode would issue a block erase that spills past the requested range. An off-by-one in the end check would either reject the last page or accept an overrun. The serial port model holds the device busy for a random number of polls and returns busy status bytes with every other bit set, so a design that tested the wrong bit or started the next erase early shows up as an early or extra frame. Requests are also injected mid-run, and the bench uses zero-length requests, so a design that accepted a request while busy or hung on a zero count is also caught.

// File: rtl/esq_pkg.sv
// Shared constants and types for the erase sequencer.
package esq_pkg;
    localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
    localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
    localparam logic [7:0] OP_STATUS      = 8'hD7;
    localparam logic [7:0] FILLER_BYTE    = 8'h00;
    localparam logic [7:0] READY_MASK     = 8'h80;
    localparam int         BLOCK_PAGES    = 8;
    localparam int         FRAME_BYTES    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WAIT,
        ST_STAT,
        ST_NEXT
    } esq_state_t;
endpackage

// File: rtl/esq_req_check.sv
// Request validation: checks page alignment of start and length and the
// device bound, and converts both to page units.
// Assumes PAGE_BYTES*NUM_PAGES fits in ADDR_W bits.
module esq_req_check #(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 264,
    parameter int NUM_PAGES  = 512,
    parameter int PAGE_W     = 10
) (
    input  logic [ADDR_W-1:0] start,
    input  logic [ADDR_W-1:0] len,
    output logic              ok,
    output logic [PAGE_W-1:0] first_page,
    output logic [PAGE_W-1:0] page_count
);
    localparam logic [ADDR_W-1:0] PB_V      = ADDR_W'(PAGE_BYTES);
    localparam logic [ADDR_W:0]   DEV_BYTES = (ADDR_W+1)'(PAGE_BYTES * NUM_PAGES);

    logic [ADDR_W:0]   end_addr;
    logic [ADDR_W-1:0] start_q, len_q;

    // Bound, alignment and page conversion.
    always_comb begin
        end_addr   = {1'b0, start} + {1'b0, len};
        start_q    = start / PB_V;
        len_q      = len / PB_V;
        first_page = PAGE_W'(start_q);
        page_count = PAGE_W'(len_q);
        ok         = ((start % PB_V) == '0) && ((len % PB_V) == '0)
                     && (end_addr <= DEV_BYTES);
    end
endmodule

// File: rtl/esq_step_plan.sv
// Step planner: chooses page or block erase for the current position and
// builds the four-byte erase frame. Assumes PAGE_SHIFT >= 8, so the low
// address byte of a page-aligned address is always zero.
module esq_step_plan
    import esq_pkg::*;
#(
    parameter int PAGE_W     = 10,
    parameter int PAGE_SHIFT = 9
) (
    input  logic [PAGE_W-1:0]            page,
    input  logic [PAGE_W-1:0]            left,
    output logic                         is_block,
    output logic [PAGE_W-1:0]            step,
    output logic [FRAME_BYTES-1:0][7:0]  frame
);
    localparam int HI_SHIFT = PAGE_SHIFT - 8;

    logic [15:0] addr_hi;

    // Opcode choice, step size and frame layout.
    always_comb begin
        is_block = (page[2:0] == 3'b000) && (left >= PAGE_W'(BLOCK_PAGES));
        step     = is_block ? PAGE_W'(BLOCK_PAGES) : PAGE_W'(1);
        addr_hi  = 16'(page) << HI_SHIFT;
        frame[0] = is_block ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
        frame[1] = addr_hi[15:8];
        frame[2] = addr_hi[7:0];
        frame[3] = 8'h00;
    end
endmodule

// File: rtl/esq_gap_timer.sv
// Poll spacing timer: loads the programmed gap and counts down to zero.
module esq_gap_timer #(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [GAP_W-1:0] gap,
    output logic             expired
);
    logic [GAP_W-1:0] cnt_q;

    // Countdown register.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load)                 cnt_q <= gap;
        else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/flash_erase_seq.sv
// Erase sequencer top: accepts a request, then loops over
// erase frame -> gap -> status poll until the range is erased.
// Assumes the byte port completes a byte in the cycle xfer_ack is high
// while xfer_req is high, and that poll_gap is held stable during a run.
module flash_erase_seq
    import esq_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 264,
    parameter int NUM_PAGES  = 512,
    parameter int PAGE_SHIFT = 9,
    parameter int GAP_W      = 4,
    parameter int PAGE_W     = $clog2(NUM_PAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_len,
    input  logic [GAP_W-1:0]  poll_gap,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [PAGE_W-1:0] pages_left,
    output logic [PAGE_W-1:0] cur_page,
    output logic              cs_n,
    output logic              xfer_req,
    output logic [7:0]        xfer_tx,
    input  logic              xfer_ack,
    input  logic [7:0]        xfer_rx
);
    esq_state_t                  state_q;
    logic [1:0]                  bidx_q;
    logic [PAGE_W-1:0]           page_q, left_q;
    logic                        done_q, err_q;

    logic                        req_ok;
    logic [PAGE_W-1:0]           req_page, req_cnt;
    logic                        step_block;
    logic [PAGE_W-1:0]           step_size;
    logic [FRAME_BYTES-1:0][7:0] frame;
    logic                        gap_load, gap_done, dev_ready;
    logic                        last_cmd_byte, last_stat_byte;

    esq_req_check #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES),
        .NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)
    ) u_check (
        .start(req_start), .len(req_len), .ok(req_ok),
        .first_page(req_page), .page_count(req_cnt)
    );

    esq_step_plan #(
        .PAGE_W(PAGE_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_plan (
        .page(page_q), .left(left_q), .is_block(step_block),
        .step(step_size), .frame(frame)
    );

    esq_gap_timer #(
        .GAP_W(GAP_W)
    ) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load),
        .run(state_q == ST_WAIT), .gap(poll_gap), .expired(gap_done)
    );

    // Byte-completion events and the ready bit of the polled status.
    always_comb begin
        dev_ready      = |(xfer_rx & READY_MASK);
        last_cmd_byte  = (state_q == ST_CMD)  && xfer_ack && (bidx_q == 2'(FRAME_BYTES - 1));
        last_stat_byte = (state_q == ST_STAT) && xfer_ack && (bidx_q == 2'd1);
        gap_load       = last_cmd_byte || (last_stat_byte && !dev_ready);
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bidx_q  <= '0;
            page_q  <= '0;
            left_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (!req_ok) begin
                            err_q <= 1'b1;
                        end else if (req_cnt == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            page_q  <= req_page;
                            left_q  <= req_cnt;
                            bidx_q  <= '0;
                            state_q <= ST_CMD;
                        end
                    end
                end
                ST_CMD: begin
                    if (xfer_ack) begin
                        bidx_q <= bidx_q + 1'b1;
                        if (last_cmd_byte) state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (gap_done) begin
                        bidx_q  <= '0;
                        state_q <= ST_STAT;
                    end
                end
                ST_STAT: begin
                    if (xfer_ack) begin
                        if (last_stat_byte) begin
                            bidx_q  <= '0;
                            state_q <= dev_ready ? ST_NEXT : ST_WAIT;
                        end else begin
                            bidx_q <= 2'd1;
                        end
                    end
                end
                ST_NEXT: begin
                    page_q <= page_q + step_size;
                    left_q <= left_q - step_size;
                    bidx_q <= '0;
                    if (left_q == step_size) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_CMD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive: select active only inside frames, byte chosen by index.
    always_comb begin
        xfer_req = (state_q == ST_CMD) || (state_q == ST_STAT);
        cs_n     = !xfer_req;
        if (state_q == ST_STAT) xfer_tx = (bidx_q == 2'd0) ? OP_STATUS : FILLER_BYTE;
        else                    xfer_tx = frame[bidx_q];
        busy       = (state_q != ST_IDLE);
        done       = done_q;
        err        = err_q;
        pages_left = left_q;
        cur_page   = page_q;
    end
endmodule

// File: rtl/flash_erase_seq_chk.sv
// Protocol checker for the erase sequencer, bound to every instance.
module flash_erase_seq_chk #(
    parameter int PAGE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [PAGE_W-1:0] pages_left,
    input logic [PAGE_W-1:0] cur_page,
    input logic              cs_n,
    input logic              xfer_req,
    input logic [7:0]        xfer_tx,
    input logic              xfer_ack
);
    a_r10_req_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !cs_n);

    a_r10_select_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_err_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    a_r9_done_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

    a_r12_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pages_left == '0));

    a_r8_left_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (pages_left <= $past(pages_left)));

    a_r8_page_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cur_page >= $past(cur_page)));

    a_r5_byte_held_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && $past(xfer_req && !xfer_ack)) |-> $stable(xfer_tx));

    a_r11_err_only_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$past(busy));
endmodule

bind flash_erase_seq flash_erase_seq_chk #(.PAGE_W(PAGE_W)) u_esq_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .pages_left(pages_left), .cur_page(cur_page), .cs_n(cs_n),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack)
);

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
    localparam int AW = 24;
    localparam int PB = 264;
    localparam int NP = 512;
    localparam int SH = 9;
    localparam int GW = 4;
    localparam int PW = $clog2(NP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_start = '0, req_len = '0;
    logic [GW-1:0] poll_gap = '0;
    logic busy, done, err, cs_n, xfer_req;
    logic [PW-1:0] pages_left, cur_page;
    logic [7:0] xfer_tx;
    logic xfer_ack = 1'b0;
    logic [7:0] xfer_rx = 8'h00;

    always #2.5 clk = ~clk;

    flash_erase_seq #(.ADDR_W(AW), .PAGE_BYTES(PB), .NUM_PAGES(NP),
                      .PAGE_SHIFT(SH), .GAP_W(GW)) i_flash_erase_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_start(req_start),
        .req_len(req_len), .poll_gap(poll_gap), .busy(busy), .done(done),
        .err(err), .pages_left(pages_left), .cur_page(cur_page), .cs_n(cs_n),
        .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack),
        .xfer_rx(xfer_rx));

    int checks = 0, errors = 0;
    bit finished = 0;

    // bench model state
    bit in_frame = 0;
    int nb = 0, gap_cnt = 1000, frame_gap = 0, wait_cnt = 0;
    logic [7:0] fb [0:7];
    bit need_ready = 0;
    int pend_busy = 0, exp_page = 0, exp_left = 0, cur_gap = 0, cmd_frames = 0;

    task automatic chk(input bit cond, input string rq, input string what,
                       input int act, input int expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic finish_sim();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic bit exp_ok(input int s, input int l);
        return (s % PB == 0) && (l % PB == 0) && (s + l <= PB * NP);
    endfunction

    function automatic int exp_frames(input int pg, input int n);
        int f = 0;
        while (n > 0) begin
            if (pg % 8 == 0 && n >= 8) begin pg += 8; n -= 8; end
            else begin pg += 1; n -= 1; end
            f++;
        end
        return f;
    endfunction

    task automatic eval_frame();
        if (nb == 4) begin
            int a = exp_page << SH;
            int op = (exp_page % 8 == 0 && exp_left >= 8) ? 8'h50 : 8'h81;
            chk(!need_ready, "R6", "erase frame before ready", 1, 0);
            chk(fb[0] == op[7:0], "R4", "opcode", fb[0], op);
            chk(fb[1] == a[23:16], "R5", "addr hi", fb[1], a[23:16]);
            chk(fb[2] == a[15:8], "R5", "addr mid", fb[2], a[15:8]);
            chk(fb[3] == 8'h00, "R5", "tail byte", fb[3], 0);
            if (op == 8'h50) begin exp_page += 8; exp_left -= 8; end
            else begin exp_page += 1; exp_left -= 1; end
            need_ready = 1;
            pend_busy = $urandom % 4;
            cmd_frames++;
        end else if (nb == 2) begin
            chk(fb[0] == 8'hD7, "R6", "status opcode", fb[0], 8'hD7);
            chk(fb[1] == 8'h00, "R6", "status filler", fb[1], 0);
            chk(frame_gap == cur_gap + 1, "R7", "gap before poll", frame_gap, cur_gap + 1);
        end else begin
            chk(0, "R10", "frame length", nb, 4);
        end
    endtask

    // Serial port responder and frame monitor, acting at falling edges.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                xfer_ack = 0; in_frame = 0;
            end else begin
                if (!cs_n && !in_frame) begin in_frame = 1; nb = 0; frame_gap = gap_cnt; end
                if (cs_n && in_frame) begin in_frame = 0; eval_frame(); gap_cnt = 0; end
                if (cs_n) gap_cnt++;
                if (xfer_req && cs_n) chk(0, "R10", "req with select high", 1, 0);
                xfer_ack = 0;
                if (xfer_req) begin
                    if (wait_cnt == 0) begin
                        xfer_ack = 1;
                        xfer_rx = 8'h3C;
                        if (nb == 1 && fb[0] == 8'hD7) begin
                            if (pend_busy > 0) begin xfer_rx = 8'h7F; pend_busy--; end
                            else begin xfer_rx = 8'h80; need_ready = 0; end
                        end
                        if (nb < 8) fb[nb] = xfer_tx;
                        nb++;
                        wait_cnt = $urandom % 3;
                    end else begin
                        wait_cnt--;
                    end
                end
            end
        end
    end

    task automatic run(input int s, input int l, input int gap,
                       input bit inject, input string rq);
        bit ok = exp_ok(s, l);
        int npg = l / PB;
        @(negedge clk);
        poll_gap = GW'(gap); cur_gap = gap;
        exp_page = s / PB; exp_left = npg; need_ready = 0; cmd_frames = 0;
        req_valid = 1; req_start = AW'(s); req_len = AW'(l);
        @(negedge clk);
        req_valid = 0;
        if (!ok) begin
            chk(err == 1, rq, "err pulse", err, 1);
            chk(busy == 0, rq, "busy after reject", busy, 0);
            @(negedge clk);
            chk(err == 0, rq, "err width", err, 0);
            repeat (3) @(negedge clk);
            chk(cmd_frames == 0 && cs_n, rq, "frames after reject", cmd_frames, 0);
        end else if (npg == 0) begin
            chk(done == 1, "R9", "zero length done", done, 1);
            chk(busy == 0, "R9", "zero length busy", busy, 0);
            @(negedge clk);
            chk(done == 0, "R9", "done width", done, 0);
            chk(cmd_frames == 0, "R9", "zero length frames", cmd_frames, 0);
        end else begin
            int t = 0;
            chk(busy == 1, "R12", "busy after accept", busy, 1);
            chk(pages_left == PW'(npg), "R12", "pages_left", pages_left, npg);
            chk(cur_page == PW'(s / PB), "R12", "cur_page", cur_page, s / PB);
            if (inject) begin
                @(negedge clk);
                req_valid = 1; req_start = '0; req_len = AW'(PB * 16);
                @(negedge clk);
                req_valid = 0;
            end
            while (!done && t < 30000) begin
                @(negedge clk);
                if (err) chk(0, rq, "err during run", 1, 0);
                t++;
            end
            chk(done == 1, "R9", "done seen", done, 1);
            chk(exp_left == 0, "R8", "model pages left", exp_left, 0);
            chk(pages_left == 0, "R12", "pages_left at done", pages_left, 0);
            chk(cmd_frames == exp_frames(s / PB, npg), inject ? "R11" : "R8",
                "erase frame count", cmd_frames, exp_frames(s / PB, npg));
            @(negedge clk);
            chk(done == 0, "R9", "done width", done, 0);
            chk(busy == 0 && cs_n, "R10", "idle after done", busy, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", 1, 0);
        finish_sim();
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cs_n == 1, "R10", "reset cs_n", cs_n, 1);
        chk(!busy && !done && !err && !xfer_req, "R10", "reset outputs", busy, 0);

        run(0, 8 * PB, 0, 0, "R4");
        run(3 * PB, 12 * PB, 2, 0, "R4");
        run(16 * PB, 20 * PB, 1, 1, "R11");
        run((NP - 1) * PB, PB, 3, 0, "R3");
        run((NP - 8) * PB, 9 * PB, 0, 0, "R3");
        run(PB + 1, PB, 0, 0, "R1");
        run(0, PB + 5, 0, 0, "R2");
        run(5 * PB, 0, 0, 0, "R9");
        run(0, NP * PB, 0, 0, "R3");
        for (int i = 0; i < 20; i++) begin
            int sp = $urandom % NP;
            int n = $urandom % 25;
            if ($urandom % 2) sp = sp & ~7;
            if (n > NP - sp) n = NP - sp;
            run(sp * PB, n * PB, $urandom % 6, (i % 5) == 0, "R8");
        end
        finish_sim();
    end
endmodule